// File: doc/BRIEF.md
# Graphics Event Status and Interrupt Controller

This block holds the control/status word and the interrupt mask word of a graphics engine, and turns five engine events into one level interrupt. The events are SIGNAL, FINISH, horizontal sync, vertical sync and end of rectangle write. Each is a one-cycle strobe from the engine. The block latches each event into a status bit. It drives `irq` high while any latched event is not masked.

One address means different things for reads and writes. A read of the status word returns the latched events, the display field, the FIFO level, a revision byte and an ID byte. A write of 1 to an event bit clears that event, and a write of 0 does nothing. Writes cannot change the revision, ID, field or FIFO fields. Bit 9 of a status write is a soft reset. Bit 8 is a flush command; it is accepted and has no effect.

A SIGNAL strobe can arrive while an earlier SIGNAL is still latched. This second SIGNAL is held in a hidden pending flag. Software promotes it into the status bit when it clears the first one. Every SIGNAL strobe also merges its ID data into a signal-ID register under a bit mask.

Top module: `gfx_evt_ctrl`

## Requirements
- R1: After reset the status word reads 0x551B4000, the mask word reads 0x00007F00, the signal-ID word reads 0, and `irq` is 0.
- R2: Status event bits are bit 0 SIGNAL, bit 1 FINISH, bit 2 HSINT, bit 3 VSINT and bit 4 EDWINT. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged. Bits 31:12 of the status word are unaffected by writes.
- R3: A status write with byte enables `bus_be` acts as a full-word write in which every byte whose enable is 0 is zero, so those bytes take no action.
- R4: The mask word keeps only bits 12:8, with bit 8 masking SIGNAL through bit 12 masking EDWINT. Bits 14:13 always read 1 and all other bits read 0. The mask word is written only when `bus_be[1]` is 1.
- R5: A FINISH, HSINT, VSINT or EDWINT strobe sets its status bit. The bit stays set if it was already set, and a strobe in the same cycle as a write-clear wins.
- R6: A SIGNAL strobe while mask bit 8 is 1 changes neither the SIGNAL status bit nor the pending flag.
- R7: An unmasked SIGNAL strobe sets status bit 0 if that bit is clear. If bit 0 is already set, the strobe sets the pending flag instead. Writing 1 to status bit 0 loads bit 0 from the pending flag and clears the pending flag.
- R8: Every SIGNAL strobe, masked or not, updates the signal-ID word as id = (id & ~sig_mask) | (sig_data & sig_mask).
- R9: A status write with bit 9 set restores the status word and the mask word to their reset values and clears the pending flag.
- R10: `irq` equals the OR over the five events of (status bit AND NOT mask bit), as registered one clock earlier. A mask write therefore re-evaluates it.
- R11: Status bit 13 (FIELD) toggles on every `ev_vblank_end` strobe.
- R12: A `fifo_upd` strobe loads `fifo_lvl` into status bits 15:14. The encoding is 00 partly filled, 01 empty, 10 almost full and 11 reserved.
- R13: Word addresses are 0 for status, 1 for mask and 2 for signal-ID. `bus_rdata` holds the addressed word from the clock after a cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ev_signal | input | 1 | SIGNAL event strobe |
| sig_data | input | 32 | ID data carried by SIGNAL |
| sig_mask | input | 32 | Bit mask for the ID merge |
| ev_finish | input | 1 | FINISH event strobe |
| ev_hsync | input | 1 | Horizontal sync event strobe |
| ev_vsync | input | 1 | Vertical sync event strobe |
| ev_rectend | input | 1 | Rectangle-write-end event strobe |
| ev_vblank_end | input | 1 | End of vertical sync, toggles FIELD |
| fifo_upd | input | 1 | FIFO level update strobe |
| fifo_lvl | input | 2 | FIFO level code |
| irq | output | 1 | Level interrupt |

## Verification
Events are raised first with their masks set and then unmasked. This separates latching from interrupt generation and shows the one-cycle lag of `irq` after a mask write. Status writes use patterns that mix 1s and 0s in the event bits, set bits in the fixed fields, and set the reset bit in a byte that is not enabled. These tell a write-1-clear apart from a plain store, and a lane-masked write apart from a full write. SIGNAL is exercised as a single throw, a double throw, and a throw while masked. The pending flag is observed through the status bit after two successive clears. Soft reset is applied with a pending SIGNAL, a toggled field and a non-empty FIFO level, so each restored piece is visible.

// File: rtl/gfx_evt_pkg.sv
package gfx_evt_pkg;
  localparam int NEVT       = 5;
  localparam int DW         = 32;
  localparam int BIT_RESET  = 9;
  localparam int BIT_FIELD  = 13;
  localparam int MSK_LSB    = 8;
  localparam logic [NEVT-1:0] MSK_RST = '1;

  typedef enum logic [1:0] {
    FIFO_PART  = 2'b00,
    FIFO_EMPTY = 2'b01,
    FIFO_FULL  = 2'b10,
    FIFO_RSVD  = 2'b11
  } fifo_lvl_e;

  typedef struct packed {
    logic            stat_wr;
    logic            soft_rst;
    logic [NEVT-1:0] clr;
    logic            mask_wr;
    logic [NEVT-1:0] mask_val;
  } wr_cmd_t;
endpackage

// File: rtl/gfx_evt_wrdec.sv
module gfx_evt_wrdec
  import gfx_evt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_STAT = 0,
  parameter int ADDR_MASK = 1
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW/8-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output wr_cmd_t           cmd
);
  localparam int NLANE = DW / 8;
  logic [DW-1:0] lane_en;
  logic [DW-1:0] eff;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_en[g*8 +: 8] = {8{bus_be[g]}};
  end

  assign eff = bus_wdata & lane_en;

  always_comb begin
    cmd.stat_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
    cmd.soft_rst = cmd.stat_wr && eff[BIT_RESET];
    cmd.clr      = cmd.stat_wr ? eff[NEVT-1:0] : '0;
    cmd.mask_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_MASK)) && bus_be[1];
    cmd.mask_val = bus_wdata[MSK_LSB +: NEVT];
  end
endmodule

// File: rtl/gfx_evt_state.sv
module gfx_evt_state
  import gfx_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  wr_cmd_t         cmd,
  input  logic            ev_signal,
  input  logic [DW-1:0]   sig_data,
  input  logic [DW-1:0]   sig_mask,
  input  logic            ev_finish,
  input  logic            ev_hsync,
  input  logic            ev_vsync,
  input  logic            ev_rectend,
  input  logic            ev_vblank_end,
  input  logic            fifo_upd,
  input  logic [1:0]      fifo_lvl,
  output logic [NEVT-1:0] evt,
  output logic [NEVT-1:0] msk,
  output logic            pend,
  output logic            field,
  output logic [1:0]      fifo,
  output logic [DW-1:0]   sigid
);
  logic [NEVT-1:0] evt_n;
  logic            pend_n;
  logic            sig_after;
  logic [NEVT-1:1] set_vec;

  assign set_vec = {ev_rectend, ev_vsync, ev_hsync, ev_finish};

  always_comb begin
    evt_n[NEVT-1:1] = (evt[NEVT-1:1] & ~cmd.clr[NEVT-1:1]) | set_vec;
    sig_after       = cmd.clr[0] ? pend : evt[0];
    pend_n          = cmd.clr[0] ? 1'b0 : pend;
    evt_n[0]        = sig_after;
    if (ev_signal && !msk[0]) begin
      if (sig_after) pend_n   = 1'b1;
      else           evt_n[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.soft_rst) begin
      evt   <= '0;
      pend  <= 1'b0;
      msk   <= MSK_RST;
      field <= 1'b0;
      fifo  <= FIFO_EMPTY;
    end else begin
      evt  <= evt_n;
      pend <= pend_n;
      if (cmd.mask_wr)   msk   <= cmd.mask_val;
      if (ev_vblank_end) field <= ~field;
      if (fifo_upd)      fifo  <= fifo_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            sigid <= '0;
    else if (ev_signal) sigid <= (sigid & ~sig_mask) | (sig_data & sig_mask);
  end
endmodule

// File: rtl/gfx_evt_irq.sv
module gfx_evt_irq
  import gfx_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic [NEVT-1:0] msk,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt & ~msk);
  end
endmodule

// File: rtl/gfx_evt_ctrl.sv
module gfx_evt_ctrl
  import gfx_evt_pkg::*;
#(
  parameter int          ADDR_W     = 2,
  parameter logic [7:0]  REV_CODE   = 8'h1B,
  parameter logic [7:0]  ID_CODE    = 8'h55,
  parameter int          ADDR_STAT  = 0,
  parameter int          ADDR_MASK  = 1,
  parameter int          ADDR_SIGID = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              ev_signal,
  input  logic [31:0]       sig_data,
  input  logic [31:0]       sig_mask,
  input  logic              ev_finish,
  input  logic              ev_hsync,
  input  logic              ev_vsync,
  input  logic              ev_rectend,
  input  logic              ev_vblank_end,
  input  logic              fifo_upd,
  input  logic [1:0]        fifo_lvl,
  output logic              irq
);
  wr_cmd_t         cmd;
  logic [NEVT-1:0] evt, msk;
  logic            pend, field;
  logic [1:0]      fifo;
  logic [DW-1:0]   sigid;
  logic [DW-1:0]   stat_word, mask_word, rd_mux;

  gfx_evt_wrdec #(.ADDR_W(ADDR_W), .ADDR_STAT(ADDR_STAT), .ADDR_MASK(ADDR_MASK)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .cmd(cmd)
  );

  gfx_evt_state u_state (
    .clk(clk), .rst(rst), .cmd(cmd),
    .ev_signal(ev_signal), .sig_data(sig_data), .sig_mask(sig_mask),
    .ev_finish(ev_finish), .ev_hsync(ev_hsync), .ev_vsync(ev_vsync),
    .ev_rectend(ev_rectend), .ev_vblank_end(ev_vblank_end),
    .fifo_upd(fifo_upd), .fifo_lvl(fifo_lvl),
    .evt(evt), .msk(msk), .pend(pend), .field(field), .fifo(fifo), .sigid(sigid)
  );

  gfx_evt_irq u_irq (.clk(clk), .rst(rst), .evt(evt), .msk(msk), .irq(irq));

  assign stat_word = {ID_CODE, REV_CODE, fifo, field, 1'b0, 7'b0, evt};
  assign mask_word = {17'b0, 2'b11, msk, 8'b0};

  always_comb begin
    if (bus_addr == ADDR_W'(ADDR_STAT))       rd_mux = stat_word;
    else if (bus_addr == ADDR_W'(ADDR_MASK))  rd_mux = mask_word;
    else if (bus_addr == ADDR_W'(ADDR_SIGID)) rd_mux = sigid;
    else                                      rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gfx_evt_chk.sv
module gfx_evt_chk
  import gfx_evt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              ev_signal,
  input logic              ev_finish,
  input logic              ev_vblank_end,
  input logic [NEVT-1:0]   evt,
  input logic [NEVT-1:0]   msk,
  input logic              pend,
  input logic              field,
  input logic              irq
);
  logic stat_wr, srst;
  assign stat_wr = bus_wr && (bus_addr == '0);
  assign srst    = stat_wr && bus_be[1] && bus_wdata[BIT_RESET];

  p_finish_set_r5: assert property (@(posedge clk) disable iff (rst)
    ev_finish && !srst |=> evt[1]);

  p_sig_masked_r6: assert property (@(posedge clk) disable iff (rst)
    ev_signal && msk[0] && !stat_wr |=> $stable(evt[0]) && $stable(pend));

  p_sig_pend_r7: assert property (@(posedge clk) disable iff (rst)
    ev_signal && !msk[0] && evt[0] && !stat_wr |=> pend);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (rst)
    srst |=> (evt == '0) && (msk == MSK_RST) && !pend && !field);

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(|(evt & ~msk)));

  p_field_toggle_r11: assert property (@(posedge clk) disable iff (rst)
    ev_vblank_end && !srst |=> field != $past(field));
endmodule

bind gfx_evt_ctrl gfx_evt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .ev_signal(ev_signal), .ev_finish(ev_finish),
  .ev_vblank_end(ev_vblank_end), .evt(evt), .msk(msk), .pend(pend),
  .field(field), .irq(irq)
);

// File: tb/tb_gfx_evt_ctrl.sv
module tb_gfx_evt_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        ev_signal = 0, ev_finish = 0, ev_hsync = 0, ev_vsync = 0;
  logic        ev_rectend = 0, ev_vblank_end = 0, fifo_upd = 0;
  logic [31:0] sig_data = 0, sig_mask = 0;
  logic [1:0]  fifo_lvl = 0;
  logic        irq;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic        rd_d = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  gfx_evt_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ev_signal(ev_signal), .sig_data(sig_data), .sig_mask(sig_mask),
    .ev_finish(ev_finish), .ev_hsync(ev_hsync), .ev_vsync(ev_vsync),
    .ev_rectend(ev_rectend), .ev_vblank_end(ev_vblank_end),
    .fifo_upd(fifo_upd), .fifo_lvl(fifo_lvl), .irq(irq)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: read data is valid at the negedge following the capture edge
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read got %08h expected %08h", r, bus_rdata, e);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string r);
    bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); req_q.push_back(r);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_be = 0; bus_wdata = 0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ev_finish = 1;
      1: ev_hsync = 1;
      2: ev_vsync = 1;
      3: ev_rectend = 1;
      4: ev_vblank_end = 1;
      default: fifo_upd = 1;
    endcase
    @(negedge clk);
    {ev_finish, ev_hsync, ev_vsync, ev_rectend, ev_vblank_end, fifo_upd} = '0;
  endtask

  task automatic sig(input logic [31:0] d, input logic [31:0] m);
    ev_signal = 1; sig_data = d; sig_mask = m;
    @(negedge clk);
    ev_signal = 0; sig_data = 0; sig_mask = 0;
  endtask

  task automatic fifo_set(input logic [1:0] l);
    fifo_lvl = l; pulse(5);
  endtask

  task automatic chk_irq(input logic e, input string r);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq got %0b expected %0b", r, irq, e);
    end
  endtask

  // irq registered: one clock after state changes
  task automatic irq_after(input logic e, input string r);
    @(negedge clk);
    chk_irq(e, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values, R13 address map
    chk_irq(0, "R1");
    rd(0, 32'h551B4000, "R1");
    rd(1, 32'h00007F00, "R1");
    rd(2, 32'h00000000, "R13");
    // R5 masked latch, R10 no irq while masked
    pulse(0);
    rd(0, 32'h551B4002, "R5");
    irq_after(0, "R10");
    wr(1, 4'hF, 32'h0000_1D00);
    chk_irq(0, "R10");
    irq_after(1, "R10");
    rd(1, 32'h00007D00, "R4");
    wr(1, 4'b0010, 32'hFFFF_1F00);
    rd(1, 32'h00007F00, "R4");
    chk_irq(0, "R10");
    wr(1, 4'b1101, 32'h0000_0000);
    rd(1, 32'h00007F00, "R4");
    wr(1, 4'hF, 32'h0000_1D00);
    // R3 byte write: reset bit in a disabled lane ignored
    wr(0, 4'b0001, 32'h0000_0302);
    rd(0, 32'h551B4000, "R3");
    rd(1, 32'h00007D00, "R3");
    chk_irq(0, "R10");
    // R2 write-1-clear with zeros and fixed fields
    pulse(1); pulse(2); pulse(3);
    rd(0, 32'h551B401C, "R5");
    wr(0, 4'hF, 32'h0000_0010);
    rd(0, 32'h551B400C, "R2");
    wr(0, 4'hF, 32'hAAAA_E008);
    rd(0, 32'h551B4004, "R2");
    pulse(1);
    rd(0, 32'h551B4004, "R5");
    wr(0, 4'hF, 32'h0000_0004);
    rd(0, 32'h551B4000, "R2");
    // R12 FIFO level
    fifo_set(2'b10); rd(0, 32'h551B8000, "R12");
    fifo_set(2'b00); rd(0, 32'h551B0000, "R12");
    fifo_set(2'b01); rd(0, 32'h551B4000, "R12");
    // R11 field toggle
    pulse(4); rd(0, 32'h551B6000, "R11");
    pulse(4); rd(0, 32'h551B4000, "R11");
    // R6 masked SIGNAL, R8 ID merge
    sig(32'h1234_5678, 32'hFFFF_0000);
    rd(0, 32'h551B4000, "R6");
    rd(2, 32'h1234_0000, "R8");
    wr(1, 4'hF, 32'h0000_1C00);
    rd(1, 32'h00007C00, "R4");
    sig(32'hAAAA_BBBB, 32'h0000_FFFF);
    rd(0, 32'h551B4001, "R7");
    rd(2, 32'h1234_BBBB, "R8");
    chk_irq(1, "R10");
    // R7 double throw
    sig(32'h0, 32'h0);
    rd(0, 32'h551B4001, "R7");
    wr(0, 4'hF, 32'h1);
    rd(0, 32'h551B4001, "R7");
    wr(0, 4'hF, 32'h1);
    rd(0, 32'h551B4000, "R7");
    irq_after(0, "R10");
    // R6 masked second throw sets no pending
    sig(32'h0, 32'h0);
    wr(1, 4'hF, 32'h0000_1D00);
    sig(32'h0, 32'h0);
    wr(1, 4'hF, 32'h0000_1C00);
    wr(0, 4'hF, 32'h1);
    rd(0, 32'h551B4000, "R6");
    // R9 soft reset with pending, field, fifo
    pulse(0); pulse(4); fifo_set(2'b10);
    sig(32'h0, 32'h0); sig(32'h0, 32'h0);
    rd(0, 32'h551BA003, "R9");
    wr(0, 4'b0010, 32'h0000_0200);
    rd(0, 32'h551B4000, "R9");
    rd(1, 32'h00007F00, "R9");
    chk_irq(0, "R9");
    wr(1, 4'hF, 32'h0000_1C00);
    wr(0, 4'hF, 32'h1);
    rd(0, 32'h551B4000, "R9");
    // R3 halfword writes
    pulse(0);
    wr(0, 4'b1100, 32'hFFFF_FFFF);
    rd(0, 32'h551B4002, "R3");
    wr(0, 4'b0011, 32'h0000_0002);
    rd(0, 32'h551B4000, "R3");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule